// File: doc/BRIEF.md
# Overlapped Address Translation and Cache Tag Lookup

This block performs a load lookup in a physically tagged, two-way set-associative cache. The translation buffer converts the virtual page number to a frame number in the same cycle that the cache arrays are indexed. The set index and the line offset are taken only from the page-offset bits of the virtual address. Those bits are the same in the virtual and the physical address, so the array read does not wait for translation. On the following cycle the frame number, joined with the untranslated offset bits, is compared against the tag read from each way. That comparison produces hit or miss and selects the data word.

The translation buffer is a small fully associative table written through a slot port. Cache lines are installed through a fill port that carries a physical line address and a whole line. A cache miss whose translation succeeded raises a one-cycle refill request carrying the line-aligned physical address. Sequencing the refill is left to the surrounding logic. The overlap is only legal when the page size is at least the cache capacity divided by the number of ways, and elaboration stops with an error if the parameters break that rule.

Top module: `vipt_lookup`

## Requirements
- R1: After reset, no translation slot and no cache line is valid, so the first lookup reports a translation miss, and `respValid` is low while no lookup is in flight.
- R2: `respValid` is high in exactly the cycle after each cycle in which `reqValid` is high, including back-to-back requests, and every other response output is low when `respValid` is low.
- R3: When no valid slot matches the virtual page number (bits [31:12]), the response has `respTlbMiss`=1, `respMiss`=1, `respHit`=0 and `refillReq`=0, whatever the cache holds.
- R4: When translation succeeds and a valid way's tag equals the physical address bits [31:12], `respHit`=1. `respData` is then 32-bit word number vaddr[4:2] of that line, where word k occupies bits [32k+31:32k] of the fill line.
- R5: When translation succeeds and no way matches, `respMiss`=1 and `refillReq` pulses for that response cycle with `refillPaddr` = {frame number, vaddr[11:5], 5'b0}.
- R6: The set is chosen by vaddr[11:5] without translation and the hit is decided by the translated frame number. Two virtual pages mapped to one frame hit the same line, and a page mapped to a different frame misses in the same set.
- R7: A fill goes to the way that already holds its tag if there is one. Otherwise it goes to an invalid way, way 0 before way 1. Two lines with different tags in one set are then both resident.
- R8: Each set keeps one replacement bit naming the least recently used way. A hit or a fill to one way makes the other way the next victim, and a fill into a full set replaces that victim.
- R9: Writing a translation slot replaces its previous mapping, so the old virtual page misses in translation and the new one translates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request this cycle |
| reqVaddr | input | 32 | Virtual address of the lookup |
| tlbWrEn | input | 1 | Write a translation slot |
| tlbWrSlot | input | 3 | Slot number to write |
| tlbWrVpn | input | 20 | Virtual page number for the slot |
| tlbWrPfn | input | 20 | Frame number for the slot |
| fillEn | input | 1 | Install a cache line |
| fillPaddr | input | 32 | Physical address of the line to install |
| fillLine | input | 256 | Line contents, word 0 in the low bits |
| respValid | output | 1 | Response present this cycle |
| respHit | output | 1 | Cache hit |
| respMiss | output | 1 | Cache miss (includes translation misses) |
| respTlbMiss | output | 1 | Translation miss |
| respData | output | 32 | Selected word on a hit, zero otherwise |
| refillReq | output | 1 | Refill request pulse after a translated miss |
| refillPaddr | output | 32 | Line-aligned physical address to refill |

## Verification
The bench builds the block with its default parameters: 4 KiB pages, an 8 KiB two-way cache with 32-byte lines, and an eight-slot translation buffer. With these values the index and line offset fill the page offset exactly, and the stored tag is the bare frame number. This lets the bench predict hits purely from the page mappings it writes. It makes aliasing between two virtual pages, and a frame mismatch within one set, directly observable. With 128 sets, a replacement sequence can be confined to one set while other sets stay untouched. Eight slots are few enough that overwriting a slot and seeing the old page fall out takes only a few writes.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic capture;    // latch translation and array read for a new lookup
    logic respond;    // response stage is live this cycle
    logic fillWrite;  // install a cache line
    logic tlbWrite;   // write a translation slot
  } lookupStrb_t;

endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ENTRIES = 8,
  localparam int SLOT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [PFN_W-1:0]  wrPfn,
  input  logic [VPN_W-1:0]  lkVpn,
  output logic              lkHit,
  output logic [PFN_W-1:0]  lkPfn
);

  logic [ENTRIES-1:0] slotVld;
  logic [VPN_W-1:0]   slotVpn [ENTRIES];
  logic [PFN_W-1:0]   slotPfn [ENTRIES];
  logic [ENTRIES-1:0] slotMatch;

  always_ff @(posedge clk) begin
    if (!rstN) slotVld <= '0;
    else if (wrEn) slotVld[wrSlot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      slotVpn[wrSlot] <= wrVpn;
      slotPfn[wrSlot] <= wrPfn;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : gMatch
    assign slotMatch[e] = slotVld[e] && (slotVpn[e] == lkVpn);
  end

  always_comb begin
    lkPfn = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (slotMatch[e]) lkPfn = lkPfn | slotPfn[e];
    end
  end

  assign lkHit = |slotMatch;

endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        fillEn,
  input  logic        tlbWrEn,
  output lookupStrb_t strb,
  output logic        respValid
);

  logic respQ;

  always_ff @(posedge clk) begin
    if (!rstN) respQ <= 1'b0;
    else       respQ <= reqValid;
  end

  always_comb begin
    strb.capture   = reqValid;
    strb.respond   = respQ;
    strb.fillWrite = fillEn;
    strb.tlbWrite  = tlbWrEn;
  end

  assign respValid = respQ;

endmodule

// File: rtl/vipt_cache_dp.sv
module vipt_cache_dp
  import vipt_pkg::*;
#(
  parameter int PFN_W      = 20,
  parameter int PAGE_OFF_W = 12,
  parameter int SETS       = 128,
  parameter int WAYS       = 2,
  parameter int LINE_BYTES = 32,
  parameter int WORD_W     = 32,
  localparam int PA_W       = PFN_W + PAGE_OFF_W,
  localparam int LINE_OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W      = $clog2(SETS),
  localparam int TAG_W      = PA_W - IDX_W - LINE_OFF_W,
  localparam int LINE_BITS  = LINE_BYTES * 8,
  localparam int WORDS      = LINE_BITS / WORD_W,
  localparam int WSEL_W     = $clog2(WORDS),
  localparam int BYTE_W     = $clog2(WORD_W / 8),
  localparam int WAY_W      = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  lookupStrb_t           strb,
  input  logic [PAGE_OFF_W-1:0] lkOff,
  input  logic                  tlbHit,
  input  logic [PFN_W-1:0]      tlbPfn,
  input  logic [PA_W-1:0]       fillPaddr,
  input  logic [LINE_BITS-1:0]  fillLine,
  output logic                  respHit,
  output logic                  respMiss,
  output logic                  respTlbMiss,
  output logic [WORD_W-1:0]     respData,
  output logic                  refillReq,
  output logic [PA_W-1:0]       refillPaddr
);

  // storage
  logic [TAG_W-1:0]     tagMem  [WAYS][SETS];
  logic [LINE_BITS-1:0] dataMem [WAYS][SETS];
  logic [SETS-1:0]      validQ  [WAYS];
  logic [SETS-1:0]      lruQ;          // way to replace next

  // request-cycle read
  logic [IDX_W-1:0]  rdIdx;
  logic [WSEL_W-1:0] rdWord;
  assign rdIdx  = lkOff[LINE_OFF_W +: IDX_W];
  assign rdWord = lkOff[BYTE_W +: WSEL_W];

  // response stage
  logic                  sTlbHit;
  logic [PFN_W-1:0]      sPfn;
  logic [PAGE_OFF_W-1:0] sOff;
  logic [TAG_W-1:0]      sTag  [WAYS];
  logic                  sVld  [WAYS];
  logic [WORD_W-1:0]     sWord [WAYS];

  always_ff @(posedge clk) begin
    if (strb.capture) begin
      sTlbHit <= tlbHit;
      sPfn    <= tlbPfn;
      sOff    <= lkOff;
      for (int w = 0; w < WAYS; w++) begin
        sTag[w]  <= tagMem[w][rdIdx];
        sVld[w]  <= validQ[w][rdIdx];
        sWord[w] <= dataMem[w][rdIdx][rdWord*WORD_W +: WORD_W];
      end
    end
  end

  // tag compare against the translated address
  logic [PA_W-1:0]  sPaddr;
  logic [TAG_W-1:0] cmpTag;
  logic [IDX_W-1:0] sIdx;
  logic [WAYS-1:0]  wayHit;
  assign sPaddr = {sPfn, sOff};
  assign cmpTag = sPaddr[PA_W-1 -: TAG_W];
  assign sIdx   = sOff[LINE_OFF_W +: IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : gCmp
    assign wayHit[w] = sTlbHit && sVld[w] && (sTag[w] == cmpTag);
  end

  logic [WAY_W-1:0]  hitWay;
  logic [WORD_W-1:0] hitData;
  logic              anyHit;

  always_comb begin
    hitWay  = '0;
    hitData = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (wayHit[w]) begin
        hitWay  = WAY_W'(w);
        hitData = sWord[w];
      end
    end
  end

  assign anyHit      = strb.respond && (|wayHit);
  assign respHit     = anyHit;
  assign respMiss    = strb.respond && !(|wayHit);
  assign respTlbMiss = strb.respond && !sTlbHit;
  assign refillReq   = strb.respond && sTlbHit && !(|wayHit);
  assign respData    = anyHit ? hitData : '0;
  assign refillPaddr = {sPaddr[PA_W-1:LINE_OFF_W], {LINE_OFF_W{1'b0}}};

  // fill placement
  logic [IDX_W-1:0] fIdx;
  logic [TAG_W-1:0] fTag;
  logic [WAYS-1:0]  fillMatch;
  logic [WAY_W-1:0] victim;
  assign fIdx = fillPaddr[LINE_OFF_W +: IDX_W];
  assign fTag = fillPaddr[PA_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : gFill
    assign fillMatch[w] = validQ[w][fIdx] && (tagMem[w][fIdx] == fTag);
  end

  always_comb begin
    if (|fillMatch)            victim = fillMatch[1];
    else if (!validQ[0][fIdx]) victim = 1'b0;
    else if (!validQ[1][fIdx]) victim = 1'b1;
    else                       victim = lruQ[fIdx];
  end

  always_ff @(posedge clk) begin
    if (strb.fillWrite) begin
      tagMem[victim][fIdx]  <= fTag;
      dataMem[victim][fIdx] <= fillLine;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < WAYS; w++) validQ[w] <= '0;
    end else if (strb.fillWrite) begin
      validQ[victim][fIdx] <= 1'b1;
    end
  end

  // replacement bit: hit updates first, a same-cycle fill overrides
  always_ff @(posedge clk) begin
    if (!rstN) lruQ <= '0;
    else begin
      if (anyHit)         lruQ[sIdx] <= ~hitWay;
      if (strb.fillWrite) lruQ[fIdx] <= ~victim;
    end
  end

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int VPN_W       = 20,
  parameter int PFN_W       = 20,
  parameter int PAGE_OFF_W  = 12,
  parameter int CACHE_BYTES = 8192,
  parameter int WAYS        = 2,
  parameter int LINE_BYTES  = 32,
  parameter int TLB_ENTRIES = 8,
  parameter int WORD_W      = 32,
  localparam int VA_W      = VPN_W + PAGE_OFF_W,
  localparam int PA_W      = PFN_W + PAGE_OFF_W,
  localparam int SETS      = CACHE_BYTES / (WAYS * LINE_BYTES),
  localparam int LINE_BITS = LINE_BYTES * 8,
  localparam int SLOT_W    = $clog2(TLB_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [VA_W-1:0]      reqVaddr,
  input  logic                 tlbWrEn,
  input  logic [SLOT_W-1:0]    tlbWrSlot,
  input  logic [VPN_W-1:0]     tlbWrVpn,
  input  logic [PFN_W-1:0]     tlbWrPfn,
  input  logic                 fillEn,
  input  logic [PA_W-1:0]      fillPaddr,
  input  logic [LINE_BITS-1:0] fillLine,
  output logic                 respValid,
  output logic                 respHit,
  output logic                 respMiss,
  output logic                 respTlbMiss,
  output logic [WORD_W-1:0]    respData,
  output logic                 refillReq,
  output logic [PA_W-1:0]      refillPaddr
);

  // Index bits must lie inside the page offset for the overlap to be legal.
  if ((64'd1 << PAGE_OFF_W) < 64'(CACHE_BYTES / WAYS)) begin : gBadPage
    $error("page size smaller than cache capacity per way");
  end
  if (WAYS != 2) begin : gBadWays
    $error("single replacement bit per set needs exactly two ways");
  end

  lookupStrb_t           strb;
  logic                  tlbHit;
  logic [PFN_W-1:0]      tlbPfn;

  vipt_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .fillEn    (fillEn),
    .tlbWrEn   (tlbWrEn),
    .strb      (strb),
    .respValid (respValid)
  );

  vipt_tlb #(
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W),
    .ENTRIES (TLB_ENTRIES)
  ) tlb_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (strb.tlbWrite),
    .wrSlot (tlbWrSlot),
    .wrVpn  (tlbWrVpn),
    .wrPfn  (tlbWrPfn),
    .lkVpn  (reqVaddr[VA_W-1 -: VPN_W]),
    .lkHit  (tlbHit),
    .lkPfn  (tlbPfn)
  );

  vipt_cache_dp #(
    .PFN_W      (PFN_W),
    .PAGE_OFF_W (PAGE_OFF_W),
    .SETS       (SETS),
    .WAYS       (WAYS),
    .LINE_BYTES (LINE_BYTES),
    .WORD_W     (WORD_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .lkOff       (reqVaddr[PAGE_OFF_W-1:0]),
    .tlbHit      (tlbHit),
    .tlbPfn      (tlbPfn),
    .fillPaddr   (fillPaddr),
    .fillLine    (fillLine),
    .respHit     (respHit),
    .respMiss    (respMiss),
    .respTlbMiss (respTlbMiss),
    .respData    (respData),
    .refillReq   (refillReq),
    .refillPaddr (refillPaddr)
  );

endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic respValid,
  input logic respHit,
  input logic respMiss,
  input logic respTlbMiss,
  input logic refillReq
);

  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);

  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);

  // R2
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> !(respHit || respMiss || respTlbMiss || refillReq));

  // R4
  hit_miss_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $onehot({respHit, respMiss}));

  // R3
  tlb_miss_forces_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    respTlbMiss |-> (respMiss && !respHit && !refillReq));

  // R5
  refill_only_translated_chk: assert property (@(posedge clk) disable iff (!rstN)
    refillReq |-> (respMiss && !respTlbMiss));

endmodule

bind vipt_lookup vipt_lookup_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .respValid   (respValid),
  .respHit     (respHit),
  .respMiss    (respMiss),
  .respTlbMiss (respTlbMiss),
  .refillReq   (refillReq)
);

// File: tb/vipt_lookup_tb.sv
module vipt_lookup_tb_top;

  logic         clk = 1'b0;
  logic         rstN;
  logic         reqValid;
  logic [31:0]  reqVaddr;
  logic         tlbWrEn;
  logic [2:0]   tlbWrSlot;
  logic [19:0]  tlbWrVpn;
  logic [19:0]  tlbWrPfn;
  logic         fillEn;
  logic [31:0]  fillPaddr;
  logic [255:0] fillLine;
  logic         respValid, respHit, respMiss, respTlbMiss, refillReq;
  logic [31:0]  respData, refillPaddr;

  always #10 clk = ~clk;

  vipt_lookup dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .tlbWrEn(tlbWrEn), .tlbWrSlot(tlbWrSlot), .tlbWrVpn(tlbWrVpn), .tlbWrPfn(tlbWrPfn),
    .fillEn(fillEn), .fillPaddr(fillPaddr), .fillLine(fillLine),
    .respValid(respValid), .respHit(respHit), .respMiss(respMiss),
    .respTlbMiss(respTlbMiss), .respData(respData),
    .refillReq(refillReq), .refillPaddr(refillPaddr)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [255:0] mkLine(input logic [19:0] pfn, input logic [6:0] setNo);
    logic [255:0] l;
    for (int i = 0; i < 8; i++) l[i*32 +: 32] = {pfn, 12'h0} ^ {22'h0, setNo, 3'(i)};
    return l;
  endfunction

  function automatic logic [31:0] expWord(input logic [19:0] pfn, input logic [31:0] va);
    return {pfn, 12'h0} ^ {22'h0, va[11:5], va[4:2]};
  endfunction

  task automatic mapPage(input logic [2:0] slot, input logic [19:0] vpn, input logic [19:0] pfn);
    @(negedge clk);
    tlbWrEn = 1'b1; tlbWrSlot = slot; tlbWrVpn = vpn; tlbWrPfn = pfn;
    @(negedge clk);
    tlbWrEn = 1'b0;
  endtask

  task automatic fill(input logic [19:0] pfn, input logic [6:0] setNo);
    @(negedge clk);
    fillEn = 1'b1; fillPaddr = {pfn, setNo, 5'h0}; fillLine = mkLine(pfn, setNo);
    @(negedge clk);
    fillEn = 1'b0;
  endtask

  // Request at one negedge; response sampled at the next negedge.
  task automatic look(input logic [31:0] va);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectHit(input string rq, input logic [31:0] va, input logic [19:0] pfn);
    look(va);
    chk(rq, "respValid", 64'(respValid), 64'd1);
    chk(rq, "respHit", 64'(respHit), 64'd1);
    chk(rq, "respData", 64'(respData), 64'(expWord(pfn, va)));
  endtask

  task automatic expectMiss(input string rq, input logic [31:0] va, input logic [19:0] pfn);
    look(va);
    chk(rq, "respMiss", 64'(respMiss), 64'd1);
    chk(rq, "respTlbMiss", 64'(respTlbMiss), 64'd0);
    chk(rq, "refillReq", 64'(refillReq), 64'd1);
    chk(rq, "refillPaddr", 64'(refillPaddr), 64'({pfn, va[11:5], 5'h0}));
  endtask

  task automatic expectTlbMiss(input string rq, input logic [31:0] va);
    look(va);
    chk(rq, "respTlbMiss", 64'(respTlbMiss), 64'd1);
    chk(rq, "respMiss", 64'(respMiss), 64'd1);
    chk(rq, "respHit", 64'(respHit), 64'd0);
    chk(rq, "refillReq", 64'(refillReq), 64'd0);
  endtask

  task automatic testReset();
    chk("R1", "respValid after reset", 64'(respValid), 64'd0);
    expectTlbMiss("R1", 32'h1234_50A0);
  endtask

  task automatic testBasicHit();
    mapPage(3'd0, 20'h12345, 20'h00ABC);
    fill(20'h00ABC, 7'd5);
    expectHit("R4", 32'h1234_50AC, 20'h00ABC);
    @(negedge clk);
    chk("R2", "respValid drops after single request", 64'(respValid), 64'd0);
    chk("R2", "respHit low when idle", 64'(respHit), 64'd0);
    expectHit("R4", 32'h1234_50BC, 20'h00ABC);
  endtask

  task automatic testCacheMiss();
    expectMiss("R5", 32'h1234_50C4, 20'h00ABC);
  endtask

  task automatic testTlbMiss();
    expectTlbMiss("R3", 32'h5555_50A0);
  endtask

  task automatic testAlias();
    mapPage(3'd1, 20'h22222, 20'h00ABC);
    expectHit("R6", 32'h2222_20A0, 20'h00ABC);
    mapPage(3'd2, 20'h33333, 20'h00DEF);
    expectMiss("R6", 32'h3333_30A0, 20'h00DEF);
  endtask

  task automatic testReplace();
    // set 9: page offset 0x120
    fill(20'h00ABC, 7'd9);
    fill(20'h00DEF, 7'd9);
    expectHit("R7", 32'h3333_3124, 20'h00DEF);
    expectHit("R7", 32'h1234_5128, 20'h00ABC);
    // refilling a resident line must not evict the other way
    fill(20'h00ABC, 7'd9);
    expectHit("R7", 32'h3333_3120, 20'h00DEF);
    expectHit("R8", 32'h1234_5120, 20'h00ABC);  // DEF now least recent
    mapPage(3'd3, 20'h44444, 20'h00777);
    fill(20'h00777, 7'd9);
    expectHit("R8", 32'h4444_413C, 20'h00777);
    expectHit("R8", 32'h1234_5130, 20'h00ABC);
    expectMiss("R8", 32'h3333_3120, 20'h00DEF);
  endtask

  task automatic testRemap();
    mapPage(3'd0, 20'h66666, 20'h00ABC);
    expectTlbMiss("R9", 32'h1234_50A0);
    expectHit("R9", 32'h6666_60A8, 20'h00ABC);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = 32'h2222_20A4;
    @(negedge clk);
    reqVaddr = 32'h5555_5000;
    chk("R2", "first of pair valid", 64'(respValid), 64'd1);
    chk("R2", "first of pair data", 64'(respData), 64'(expWord(20'h00ABC, 32'h2222_20A4)));
    @(negedge clk);
    reqValid = 1'b0;
    chk("R2", "second of pair valid", 64'(respValid), 64'd1);
    chk("R2", "second of pair tlb miss", 64'(respTlbMiss), 64'd1);
    @(negedge clk);
    chk("R2", "idle after pair", 64'(respValid), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqVaddr = '0;
    tlbWrEn = 1'b0; tlbWrSlot = '0; tlbWrVpn = '0; tlbWrPfn = '0;
    fillEn = 1'b0; fillPaddr = '0; fillLine = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasicHit();
    testCacheMiss();
    testTlbMiss();
    testAlias();
    testReplace();
    testRemap();
    testBackToBack();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule